// File: doc/BRIEF.md
# Serial Register-File Target with Auto-Incrementing Pointer

This block is an I2C target that gives a host controller access to seven 8-bit configuration registers at addresses 1 to 7. It watches SCL and SDA through a two-flop synchroniser in the system clock domain. It detects START, STOP and repeated START, answers a fixed 7-bit device address, and takes a register pointer byte followed by any number of data bytes. The pointer moves forward by one after every byte that is written or sent back, so one transaction can cover several registers.

The register contents leave the block on one flat bus for the rest of the chip. Three sticky status bits in register 1 are set by hardware event inputs. A bus write can clear them but never set them. Each clear produces a one-cycle strobe per bit. Some bits are fixed, and addresses outside 1 to 7 are inert. SDA is only ever pulled low through an output-enable.

Top module: `i2c_regfile_target`

## Requirements
- R1: The target acknowledges an address byte only when its upper seven bits equal 0x58 (0xB0 to write, 0xB1 to read). Any other address is not acknowledged, and the bytes that follow it are ignored until the next START.
- R2: Bits are taken MSB first on SCL rising edges. The target holds SDA low for the whole ninth clock after a matched address byte and after every byte written to it.
- R3: A START or repeated START (SDA falling while SCL is high) always restarts the address phase and releases SDA. A STOP (SDA rising while SCL is high) returns the target to idle with SDA released.
- R4: In a write, the first byte after the address loads the pointer. Each further data byte is stored at the pointer, and the pointer then advances by one.
- R5: After a repeated START with the read bit set, the target sends the byte at the pointer MSB first and advances the pointer. It sends the next byte after each ACK from the controller and stops driving after a NACK.
- R6: After reset, registers 1 to 7 hold 0xC3, 0x05, 0x0B, 0x00, 0x06, 0x3A, 0xC2. In `cfg_o`, register k sits in bits [8k-1:8k-8].
- R7: Register 1 bit 1 always reads 1. Bits 7:6 of registers 2 to 5 and bits 3:2 of register 7 always read 0, whatever is written.
- R8: Register 1 bits 4, 3 and 2 are set by `flag_set_i[2]`, `[1]` and `[0]` respectively. A write of 0 clears a bit, and a write of 1 leaves it unchanged. A set event wins over a clear in the same cycle. Each clear pulses `status_clr_o` for one cycle, in the same bit order.
- R9: Writes to pointer 0 or to pointers 0x08 and above change nothing, and reads from those pointers return 0x00.
- R10: The pointer wraps from 0xFF to 0x00.
- R11: SDA is driven only as a low, through `sda_oe_o`, and never while the target is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| sda_oe_o | output | 1 | When 1, pull SDA low |
| flag_set_i | input | 3 | Hardware events setting register 1 bits 4, 3, 2 |
| status_clr_o | output | 3 | One-cycle pulse per status bit cleared by a write |
| cfg_o | output | 56 | Registers 1 to 7, register k in bits [8k-1:8k-8] |

## Verification
The bench drives single-byte writes, bursts across three registers and pointer-then-read transactions with a repeated START. Together these show that the pointer loads and advances on both the write path and the read path. A foreign address, a burst starting at 0xFF and a write to a reserved pointer show that the address match and the pointer wrap are exact: a wrong wrap or decode would land data in register 1 or 2. Writes of all-ones, all-zeros and mixed patterns to registers with fixed and sticky bits tell the writable bits from the constant bits. They also separate write-one-no-effect from write-zero-clear, with the clear strobes counted by value.

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target #(
  parameter logic [6:0] DEV_ADDR = 7'h58
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe_o,
  input  logic [2:0]  flag_set_i,
  output logic [2:0]  status_clr_o,
  output logic [55:0] cfg_o
);
  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK} st_t;
  localparam logic [1:0] K_ADDR = 2'd0, K_PTR = 2'd1, K_DATA = 2'd2;

  logic [2:0] scl_q, sda_q;
  st_t        state;
  logic [1:0] kind;
  logic       rw, nack;
  logic [3:0] bitcnt;
  logic [7:0] shreg, txsr, ptr, rd_data;
  logic [7:0] rf [8];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end

  wire scl_rise  = scl_q[1] & ~scl_q[2];
  wire scl_fall  = ~scl_q[1] & scl_q[2];
  wire start_det = scl_q[1] & scl_q[2] & ~sda_q[1] & sda_q[2];
  wire stop_det  = scl_q[1] & scl_q[2] & sda_q[1] & ~sda_q[2];
  wire sda_bit   = sda_q[1];

  wire we = (state == ST_RX) && !start_det && !stop_det && scl_fall
            && (bitcnt == 4'd8) && (kind == K_DATA);

  assign rd_data      = (ptr[7:3] == 5'd0) ? rf[ptr[2:0]] : 8'h00;
  assign status_clr_o = (we && ptr == 8'd1) ? ~shreg[4:2] : 3'b000;
  assign cfg_o        = {rf[7], rf[6], rf[5], rf[4], rf[3], rf[2], rf[1]};

  function automatic logic [7:0] wmask(input int idx);
    case (idx)
      1:       return 8'hE1;
      2, 3, 4, 5: return 8'h3F;
      6:       return 8'hFF;
      7:       return 8'hF3;
      default: return 8'h00;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rf[0] <= 8'h00; rf[1] <= 8'hC3; rf[2] <= 8'h05; rf[3] <= 8'h0B;
      rf[4] <= 8'h00; rf[5] <= 8'h06; rf[6] <= 8'h3A; rf[7] <= 8'hC2;
    end else begin
      for (int i = 1; i < 8; i++)
        if (we && ptr == 8'(i))
          rf[i] <= (rf[i] & ~wmask(i)) | (shreg & wmask(i));
      rf[1][4:2] <= (rf[1][4:2] & ~status_clr_o) | flag_set_i;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= ST_IDLE; kind <= K_ADDR; rw <= 1'b0; nack <= 1'b1;
      bitcnt <= '0; shreg <= '0; txsr <= '0; ptr <= '0; sda_oe_o <= 1'b0;
    end else if (start_det) begin
      state <= ST_RX; kind <= K_ADDR; bitcnt <= '0; sda_oe_o <= 1'b0;
    end else if (stop_det) begin
      state <= ST_IDLE; sda_oe_o <= 1'b0;
    end else begin
      case (state)
        ST_RX:
          if (scl_rise) begin
            shreg  <= {shreg[6:0], sda_bit};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            state    <= ST_ACK;
            sda_oe_o <= 1'b1;
            case (kind)
              K_ADDR:
                if (shreg[7:1] != DEV_ADDR) begin
                  state <= ST_IDLE; sda_oe_o <= 1'b0;
                end else rw <= shreg[0];
              K_PTR: begin ptr <= shreg; kind <= K_DATA; end
              default: ptr <= ptr + 8'd1;
            endcase
          end
        ST_ACK:
          if (scl_fall) begin
            bitcnt <= '0;
            if (kind == K_ADDR && rw) begin
              state <= ST_TX; txsr <= rd_data; sda_oe_o <= ~rd_data[7];
            end else begin
              state <= ST_RX; sda_oe_o <= 1'b0;
              if (kind == K_ADDR) kind <= K_PTR;
            end
          end
        ST_TX:
          if (scl_fall) begin
            if (bitcnt == 4'd7) begin
              state <= ST_MACK; sda_oe_o <= 1'b0; ptr <= ptr + 8'd1;
            end else begin
              txsr     <= {txsr[6:0], 1'b0};
              sda_oe_o <= ~txsr[6];
              bitcnt   <= bitcnt + 4'd1;
            end
          end
        ST_MACK:
          if (scl_rise) nack <= sda_bit;
          else if (scl_fall) begin
            if (!nack) begin
              state <= ST_TX; txsr <= rd_data; sda_oe_o <= ~rd_data[7]; bitcnt <= '0;
            end else state <= ST_IDLE;
          end
        default: ;
      endcase
    end

  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_IDLE |-> !sda_oe_o); // R11
  AST_DRIVE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe_o |-> (state == ST_ACK || state == ST_TX)); // R2
  AST_START_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == ST_RX && !sda_oe_o)); // R3
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state == ST_IDLE && !sda_oe_o)); // R3
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    |(rf[1][4:2] & ~status_clr_o) |=>
      ((rf[1][4:2] & $past(rf[1][4:2] & ~status_clr_o)) == $past(rf[1][4:2] & ~status_clr_o))); // R8
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    |flag_set_i |=> ((rf[1][4:2] & $past(flag_set_i)) == $past(flag_set_i))); // R8
endmodule

// File: tb/i2c_regfile_target_tb.sv
module i2c_regfile_target_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe;
  logic [2:0] flag_set = 3'b000, clr;
  logic [55:0] cfg;
  logic sda_line;
  int total = 0, bad = 0, clr_cnt = 0;
  logic [2:0] clr_last = 3'b000;
  logic [7:0] exp_r [1:8];
  bit done = 0;

  always #4 clk = ~clk;
  assign sda_line = m_sda & ~sda_oe;

  i2c_regfile_target u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .flag_set_i(flag_set), .status_clr_o(clr), .cfg_o(cfg));

  always @(posedge clk) if (clr != 3'b000) begin clr_cnt++; clr_last = clr; end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%0h expected=%0h", req, act, expv); end
  endtask

  task automatic hq(); repeat (10) @(negedge clk); endtask

  task automatic bus_start();
    m_sda = 1; hq(); m_scl = 1; hq(); m_sda = 0; hq(); m_scl = 0; hq();
  endtask
  task automatic bus_stop();
    m_sda = 0; hq(); m_scl = 1; hq(); m_sda = 1; hq();
  endtask
  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; hq(); m_scl = 1; hq(); hq(); m_scl = 0; hq();
    end
    m_sda = 1; hq(); m_scl = 1; hq(); ack = !sda_line; hq(); m_scl = 0; hq();
  endtask
  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1; hq(); m_scl = 1; hq(); b[i] = sda_line; hq(); m_scl = 0; hq();
    end
    m_sda = !give_ack; hq(); m_scl = 1; hq(); hq(); m_scl = 0; hq(); m_sda = 1;
  endtask

  task automatic check_regs(input string req);
    for (int k = 1; k <= 7; k++)
      check(cfg[8*k-1 -: 8] == exp_r[k], req, cfg[8*k-1 -: 8], exp_r[k]);
  endtask

  task automatic wr_seq(input logic [7:0] p, input logic [7:0] d0, d1, d2, input int n);
    logic a;
    bus_start();
    send_byte(8'hB0, a); check(a, "R1 address ack", a, 1);
    send_byte(p, a);     check(a, "R2 pointer ack", a, 1);
    if (n > 0) begin send_byte(d0, a); check(a, "R2 data ack", a, 1); end
    if (n > 1) begin send_byte(d1, a); check(a, "R2 data ack", a, 1); end
    if (n > 2) begin send_byte(d2, a); check(a, "R2 data ack", a, 1); end
    bus_stop(); hq();
  endtask

  task automatic rd_seq(input logic [7:0] p, input int n, output logic [7:0] g0, g1, g2);
    logic a;
    g0 = 0; g1 = 0; g2 = 0;
    bus_start();
    send_byte(8'hB0, a); send_byte(p, a);
    bus_start();
    send_byte(8'hB1, a); check(a, "R1 read address ack", a, 1);
    recv_byte(n > 1, g0);
    if (n > 1) recv_byte(n > 2, g1);
    if (n > 2) recv_byte(1'b0, g2);
    bus_stop(); hq();
    check(!sda_oe, "R11 released after read", sda_oe, 0);
  endtask

  task automatic t_reset();
    check_regs("R6 reset defaults");
    check(!sda_oe, "R11 idle no drive", sda_oe, 0);
  endtask

  task automatic t_single();
    wr_seq(8'h05, 8'h1F, 0, 0, 1); exp_r[5] = 8'h1F;
    check_regs("R4 single write");
  endtask

  task automatic t_burst();
    wr_seq(8'h02, 8'h3F, 8'hFF, 8'h12, 3);
    exp_r[2] = 8'h3F; exp_r[3] = 8'h3F; exp_r[4] = 8'h12;
    check_regs("R4 R7 burst write");
  endtask

  task automatic t_read();
    logic [7:0] g0, g1, g2;
    rd_seq(8'h02, 3, g0, g1, g2);
    check(g0 == exp_r[2], "R5 read byte0", g0, exp_r[2]);
    check(g1 == exp_r[3], "R5 read byte1", g1, exp_r[3]);
    check(g2 == exp_r[4], "R5 read byte2", g2, exp_r[4]);
  endtask

  task automatic t_badaddr();
    logic a;
    bus_start();
    send_byte(8'hB2, a); check(!a, "R1 foreign address no ack", a, 0);
    send_byte(8'h05, a); send_byte(8'h00, a);
    check(!a, "R1 ignored bytes no ack", a, 0);
    bus_stop(); hq();
    check_regs("R1 foreign address no write");
  endtask

  task automatic t_const();
    wr_seq(8'h01, 8'h00, 0, 0, 1); exp_r[1] = 8'h02;
    wr_seq(8'h07, 8'hFF, 0, 0, 1); exp_r[7] = 8'hF3;
    check_regs("R7 constant bits");
  endtask

  task automatic t_flags();
    logic [7:0] g0, g1, g2;
    @(negedge clk) flag_set = 3'b111;
    @(negedge clk) flag_set = 3'b000;
    @(negedge clk);
    exp_r[1] = 8'h1E; check_regs("R8 hardware set");
    clr_cnt = 0;
    wr_seq(8'h01, 8'hFF, 0, 0, 1); exp_r[1] = 8'hFF;
    check_regs("R8 write one keeps");
    check(clr_cnt == 0, "R8 no clear strobe on ones", clr_cnt, 0);
    wr_seq(8'h01, 8'hEB, 0, 0, 1); exp_r[1] = 8'hEB;
    check_regs("R8 write zero clears");
    check(clr_cnt == 1, "R8 strobe count", clr_cnt, 1);
    check(clr_last == 3'b101, "R8 strobe bits", clr_last, 3'b101);
    rd_seq(8'h01, 1, g0, g1, g2);
    check(g0 == 8'hEB, "R8 readback", g0, 8'hEB);
  endtask

  task automatic t_reserved();
    logic [7:0] g0, g1, g2;
    wr_seq(8'h08, 8'h55, 8'h66, 0, 2);
    wr_seq(8'h00, 8'h77, 0, 0, 1);
    check_regs("R9 reserved write ignored");
    rd_seq(8'h09, 1, g0, g1, g2);
    check(g0 == 8'h00, "R9 reserved read zero", g0, 0);
  endtask

  task automatic t_wrap();
    wr_seq(8'hFF, 8'h11, 8'h22, 8'hC1, 3);
    exp_r[1] = 8'hC3;
    check_regs("R10 pointer wrap");
  endtask

  task automatic t_restart();
    logic a;
    logic [7:0] g0, g1, g2;
    bus_start();
    send_byte(8'hB0, a); send_byte(8'h06, a); send_byte(8'h00, a);
    bus_start();
    send_byte(8'hB0, a); check(a, "R3 repeated start address ack", a, 1);
    send_byte(8'h07, a); send_byte(8'h81, a);
    bus_stop(); hq();
    exp_r[6] = 8'h00; exp_r[7] = 8'h81;
    check_regs("R3 repeated start write");
    rd_seq(8'h06, 3, g0, g1, g2);
    check(g0 == 8'h00, "R5 read reg6", g0, 0);
    check(g1 == 8'h81, "R5 read reg7", g1, 8'h81);
    check(g2 == 8'h00, "R9 read past end", g2, 0);
  endtask

  initial begin
    exp_r[1] = 8'hC3; exp_r[2] = 8'h05; exp_r[3] = 8'h0B; exp_r[4] = 8'h00;
    exp_r[5] = 8'h06; exp_r[6] = 8'h3A; exp_r[7] = 8'hC2; exp_r[8] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    t_reset();
    t_single();
    t_burst();
    t_read();
    t_badaddr();
    t_const();
    t_flags();
    t_reserved();
    t_wrap();
    t_restart();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule